// File: doc/BRIEF.md
# Configuration address/data port decoder

This block sits inside a host bridge and turns processor I/O port accesses into configuration requests for the devices behind the bridge. Software first writes a 32-bit selector into the address port (port 0x0CF8). The selector holds an enable flag, the target bus, device and function, and a dword register offset. Software then reads or writes the data window (port 0x0CFC). Each data-window access, while the enable flag is set, becomes exactly one downstream configuration request. The block holds that request until the responder reports completion, then answers the processor.

The address port changes only on a full four-byte write. Narrower accesses that touch it, and any access to a port the block does not own, are flagged as forwarded so that the ordinary I/O path can take them. A request aimed at bus 0 is marked as a local (type-0) request. A request aimed at any other bus is marked for a downstream bridge (type-1).

Top module: `cfg_window_decoder`

## Requirements
- R1: After reset the block asserts neither `cfg_req` nor `io_ready`, and a dword read of the address port returns 0.
- R2: A dword write (`io_be` = 4'hF) to the address port latches the selector. A following dword read of that port returns the written value ANDed with 0x80FFFFFC, so bits 30:24 and 1:0 read as zero. Writing 0x80000000 reads back 0x80000000, and writing 0 reads back 0.
- R3: A write or read to the address port with `io_be` other than 4'hF, and any access to a port other than the two owned ports, asserts `io_fwd` in the cycle it is presented, gets no `io_ready`, and leaves the latched selector unchanged.
- R4: With selector bit 31 set, a data-window access issues exactly one request. The request carries bus = selector[23:16], device = selector[15:11], function = selector[10:8], dword offset = selector[7:2], `cfg_be` = `io_be`, `cfg_wdata` = `io_wdata` and `cfg_write` = `io_write`.
- R5: With selector bit 31 clear, a data-window access issues no request. A read returns 0xFFFFFFFF, and a write has no effect.
- R6: `cfg_type1` is 1 when the request's bus number is nonzero and 0 when it is 0.
- R7: `cfg_req` and all request fields stay unchanged until `cfg_done`. `io_ready` is a one-cycle pulse in the cycle after the completion is taken, and a read returns `cfg_rdata`.
- R8: A read completion with `cfg_nodev` = 1 returns 0xFFFFFFFF to the processor.
- R9: Device 31 and function 7 (selector bits 15:11 all ones, bits 10:8 all ones) are carried into the request unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_valid | input | 1 | I/O access presented; held until `io_ready` or dropped after `io_fwd` |
| io_write | input | 1 | 1 = write, 0 = read |
| io_waddr | input | IO_AW-2 | Dword port address (port number >> 2) |
| io_be | input | DW/8 | Byte enables, one per byte lane of the dword |
| io_wdata | input | DW | Write data |
| io_ready | output | 1 | Access completed (one-cycle pulse) |
| io_rdata | output | DW | Read data, valid with `io_ready` |
| io_fwd | output | 1 | Access not owned by this block; pass it to the normal I/O path |
| cfg_req | output | 1 | Configuration request pending |
| cfg_write | output | 1 | Request is a write |
| cfg_type1 | output | 1 | Request targets a nonzero bus |
| cfg_bus | output | BUS_W | Target bus |
| cfg_dev | output | DEV_W | Target device |
| cfg_fn | output | FN_W | Target function |
| cfg_off | output | OFF_W | Dword register offset |
| cfg_be | output | DW/8 | Request byte enables |
| cfg_wdata | output | DW | Request write data |
| cfg_done | input | 1 | Responder completion for the pending request |
| cfg_rdata | input | DW | Completion read data |
| cfg_nodev | input | 1 | Completion reports that no device answered |

## Verification
The hardest case is a narrow write that lands on the address port while a valid selector is latched. The write must be forwarded, and its data must not leak into the selector, which can only be seen through a later full read. The stimulus therefore latches a selector with distinct field values, issues byte and word writes of zero to the address port, and reads the selector back. The bench also acts as the downstream responder with an adjustable completion delay, so a request can be held for several cycles and its fields compared against those decoded from the selector. Reads of the selector follow enable-clear and enable-set writes, to show that the window opens and closes.

// File: rtl/cfgdec_pkg.sv
package cfgdec_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_RESP = 2'd2
  } seq_state_e;
endpackage

// File: rtl/cfg_sel_latch.sv
module cfg_sel_latch #(
  parameter int DW    = 32,
  parameter int BUS_W = 8,
  parameter int DEV_W = 5,
  parameter int FN_W  = 3,
  parameter int OFF_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             en_in,
  input  logic [BUS_W-1:0] bus_in,
  input  logic [DEV_W-1:0] dev_in,
  input  logic [FN_W-1:0]  fn_in,
  input  logic [OFF_W-1:0] off_in,
  output logic             en_q,
  output logic [BUS_W-1:0] bus_q,
  output logic [DEV_W-1:0] dev_q,
  output logic [FN_W-1:0]  fn_q,
  output logic [OFF_W-1:0] off_q,
  output logic [DW-1:0]    sel_word
);
  localparam int OFF_LSB = 2;
  localparam int FN_LSB  = OFF_LSB + OFF_W;
  localparam int DEV_LSB = FN_LSB + FN_W;
  localparam int BUS_LSB = DEV_LSB + DEV_W;
  localparam int EN_BIT  = DW - 1;

  // Only implemented fields are stored; unimplemented bits read as zero.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      bus_q <= '0;
      dev_q <= '0;
      fn_q  <= '0;
      off_q <= '0;
    end else if (wr_en) begin
      en_q  <= en_in;
      bus_q <= bus_in;
      dev_q <= dev_in;
      fn_q  <= fn_in;
      off_q <= off_in;
    end
  end

  always_comb begin
    sel_word                     = '0;
    sel_word[EN_BIT]             = en_q;
    sel_word[BUS_LSB +: BUS_W]   = bus_q;
    sel_word[DEV_LSB +: DEV_W]   = dev_q;
    sel_word[FN_LSB +: FN_W]     = fn_q;
    sel_word[OFF_LSB +: OFF_W]   = off_q;
  end
endmodule

// File: rtl/cfg_seq.sv
module cfg_seq
  import cfgdec_pkg::*;
#(
  parameter int              IO_AW     = 16,
  parameter logic [IO_AW-1:0] ADDR_PORT = 16'h0CF8,
  parameter logic [IO_AW-1:0] DATA_PORT = 16'h0CFC,
  parameter int              DW        = 32,
  parameter int              BUS_W     = 8,
  parameter int              DEV_W     = 5,
  parameter int              FN_W      = 3,
  parameter int              OFF_W     = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               io_valid,
  input  logic               io_write,
  input  logic [IO_AW-3:0]   io_waddr,
  input  logic [DW/8-1:0]    io_be,
  input  logic [DW-1:0]      io_wdata,
  output logic               io_ready,
  output logic [DW-1:0]      io_rdata,
  output logic               io_fwd,
  output logic               sel_wr,
  input  logic               en,
  input  logic [BUS_W-1:0]   bus,
  input  logic [DEV_W-1:0]   dev,
  input  logic [FN_W-1:0]    fn,
  input  logic [OFF_W-1:0]   off,
  input  logic [DW-1:0]      sel_word,
  output logic               cfg_req,
  output logic               cfg_write,
  output logic               cfg_type1,
  output logic [BUS_W-1:0]   cfg_bus,
  output logic [DEV_W-1:0]   cfg_dev,
  output logic [FN_W-1:0]    cfg_fn,
  output logic [OFF_W-1:0]   cfg_off,
  output logic [DW/8-1:0]    cfg_be,
  output logic [DW-1:0]      cfg_wdata,
  input  logic               cfg_done,
  input  logic [DW-1:0]      cfg_rdata,
  input  logic               cfg_nodev
);
  localparam int BE_W = DW / 8;
  localparam logic [IO_AW-3:0] ADDR_DW = ADDR_PORT[IO_AW-1:2];
  localparam logic [IO_AW-3:0] DATA_DW = DATA_PORT[IO_AW-1:2];

  seq_state_e     st_q, st_d;
  logic           req_q, req_d;
  logic           launch;
  logic           rdata_ld;
  logic [DW-1:0]  rdata_q, rdata_d;

  logic hit_sel, hit_win, full_dw, claim_sel, idle;

  assign hit_sel   = (io_waddr == ADDR_DW);
  assign hit_win   = (io_waddr == DATA_DW);
  assign full_dw   = (io_be == {BE_W{1'b1}});
  assign claim_sel = hit_sel && full_dw;
  assign idle      = (st_q == ST_IDLE);

  assign sel_wr   = io_valid && idle && io_write && claim_sel;
  assign io_fwd   = io_valid && idle && !claim_sel && !hit_win;
  assign io_ready = (st_q == ST_RESP);
  assign io_rdata = rdata_q;
  assign cfg_req  = req_q;

  always_comb begin
    st_d     = st_q;
    req_d    = req_q;
    launch   = 1'b0;
    rdata_ld = 1'b0;
    rdata_d  = rdata_q;
    case (st_q)
      ST_IDLE: begin
        if (io_valid && claim_sel) begin
          st_d     = ST_RESP;
          rdata_ld = 1'b1;
          rdata_d  = sel_word;
        end else if (io_valid && hit_win) begin
          if (en) begin
            st_d   = ST_WAIT;
            req_d  = 1'b1;
            launch = 1'b1;
          end else begin
            st_d     = ST_RESP;
            rdata_ld = 1'b1;
            rdata_d  = '1;
          end
        end
      end
      ST_WAIT: begin
        if (cfg_done) begin
          st_d     = ST_RESP;
          req_d    = 1'b0;
          rdata_ld = 1'b1;
          rdata_d  = cfg_nodev ? '1 : cfg_rdata;
        end
      end
      ST_RESP: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      req_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      req_q <= req_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (rdata_ld) begin
      rdata_q <= rdata_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_write <= 1'b0;
      cfg_type1 <= 1'b0;
      cfg_bus   <= '0;
      cfg_dev   <= '0;
      cfg_fn    <= '0;
      cfg_off   <= '0;
      cfg_be    <= '0;
      cfg_wdata <= '0;
    end else if (launch) begin
      cfg_write <= io_write;
      cfg_type1 <= (bus != '0);
      cfg_bus   <= bus;
      cfg_dev   <= dev;
      cfg_fn    <= fn;
      cfg_off   <= off;
      cfg_be    <= io_be;
      cfg_wdata <= io_wdata;
    end
  end

  // R7
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_req && !cfg_done |=> cfg_req && $stable(cfg_bus) && $stable(cfg_dev)
      && $stable(cfg_fn) && $stable(cfg_off) && $stable(cfg_be) && $stable(cfg_wdata));

  // R7
  ready_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    io_ready |=> !io_ready);

  // R8
  nodev_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_req && cfg_done && cfg_nodev && !cfg_write |=> io_ready && (io_rdata == '1));

  // R5
  req_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_req) |-> $past(en));
endmodule

// File: rtl/cfg_window_decoder.sv
module cfg_window_decoder #(
  parameter int               IO_AW     = 16,
  parameter logic [IO_AW-1:0] ADDR_PORT = 16'h0CF8,
  parameter logic [IO_AW-1:0] DATA_PORT = 16'h0CFC,
  parameter int               DW        = 32,
  parameter int               BUS_W     = 8,
  parameter int               DEV_W     = 5,
  parameter int               FN_W      = 3,
  parameter int               OFF_W     = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               io_valid,
  input  logic               io_write,
  input  logic [IO_AW-3:0]   io_waddr,
  input  logic [DW/8-1:0]    io_be,
  input  logic [DW-1:0]      io_wdata,
  output logic               io_ready,
  output logic [DW-1:0]      io_rdata,
  output logic               io_fwd,
  output logic               cfg_req,
  output logic               cfg_write,
  output logic               cfg_type1,
  output logic [BUS_W-1:0]   cfg_bus,
  output logic [DEV_W-1:0]   cfg_dev,
  output logic [FN_W-1:0]    cfg_fn,
  output logic [OFF_W-1:0]   cfg_off,
  output logic [DW/8-1:0]    cfg_be,
  output logic [DW-1:0]      cfg_wdata,
  input  logic               cfg_done,
  input  logic [DW-1:0]      cfg_rdata,
  input  logic               cfg_nodev
);
  localparam int OFF_LSB = 2;
  localparam int FN_LSB  = OFF_LSB + OFF_W;
  localparam int DEV_LSB = FN_LSB + FN_W;
  localparam int BUS_LSB = DEV_LSB + DEV_W;
  localparam int EN_BIT  = DW - 1;

  // Reset asserts asynchronously, releases on a clock edge.
  logic [1:0] rst_sync_q;
  logic       srst_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign srst_n = rst_sync_q[1];

  logic             sel_wr, en_q;
  logic [BUS_W-1:0] bus_q;
  logic [DEV_W-1:0] dev_q;
  logic [FN_W-1:0]  fn_q;
  logic [OFF_W-1:0] off_q;
  logic [DW-1:0]    sel_word;

  cfg_sel_latch #(
    .DW(DW), .BUS_W(BUS_W), .DEV_W(DEV_W), .FN_W(FN_W), .OFF_W(OFF_W)
  ) u_sel (
    .clk      (clk),
    .rst_n    (srst_n),
    .wr_en    (sel_wr),
    .en_in    (io_wdata[EN_BIT]),
    .bus_in   (io_wdata[BUS_LSB +: BUS_W]),
    .dev_in   (io_wdata[DEV_LSB +: DEV_W]),
    .fn_in    (io_wdata[FN_LSB +: FN_W]),
    .off_in   (io_wdata[OFF_LSB +: OFF_W]),
    .en_q     (en_q),
    .bus_q    (bus_q),
    .dev_q    (dev_q),
    .fn_q     (fn_q),
    .off_q    (off_q),
    .sel_word (sel_word)
  );

  cfg_seq #(
    .IO_AW(IO_AW), .ADDR_PORT(ADDR_PORT), .DATA_PORT(DATA_PORT), .DW(DW),
    .BUS_W(BUS_W), .DEV_W(DEV_W), .FN_W(FN_W), .OFF_W(OFF_W)
  ) u_seq (
    .clk       (clk),
    .rst_n     (srst_n),
    .io_valid  (io_valid),
    .io_write  (io_write),
    .io_waddr  (io_waddr),
    .io_be     (io_be),
    .io_wdata  (io_wdata),
    .io_ready  (io_ready),
    .io_rdata  (io_rdata),
    .io_fwd    (io_fwd),
    .sel_wr    (sel_wr),
    .en        (en_q),
    .bus       (bus_q),
    .dev       (dev_q),
    .fn        (fn_q),
    .off       (off_q),
    .sel_word  (sel_word),
    .cfg_req   (cfg_req),
    .cfg_write (cfg_write),
    .cfg_type1 (cfg_type1),
    .cfg_bus   (cfg_bus),
    .cfg_dev   (cfg_dev),
    .cfg_fn    (cfg_fn),
    .cfg_off   (cfg_off),
    .cfg_be    (cfg_be),
    .cfg_wdata (cfg_wdata),
    .cfg_done  (cfg_done),
    .cfg_rdata (cfg_rdata),
    .cfg_nodev (cfg_nodev)
  );

  // R3
  partial_keep_chk: assert property (@(posedge clk) disable iff (!srst_n)
    io_fwd && io_write |=> $stable(sel_word));
endmodule

// File: tb/tb_cfg_window_decoder.sv
`timescale 1ns/1ps
module tb_cfg_window_decoder;
  localparam logic [13:0] AP = 14'h33E; // 0x0CF8 >> 2
  localparam logic [13:0] DP = 14'h33F; // 0x0CFC >> 2
  localparam logic [13:0] OP = 14'h33D; // 0x0CF4 >> 2

  logic        clk = 1'b0;
  logic        rst_n;
  logic        io_valid, io_write;
  logic [13:0] io_waddr;
  logic [3:0]  io_be;
  logic [31:0] io_wdata;
  logic        io_ready, io_fwd;
  logic [31:0] io_rdata;
  logic        cfg_req, cfg_write, cfg_type1;
  logic [7:0]  cfg_bus;
  logic [4:0]  cfg_dev;
  logic [2:0]  cfg_fn;
  logic [5:0]  cfg_off;
  logic [3:0]  cfg_be;
  logic [31:0] cfg_wdata;
  logic        cfg_done, cfg_nodev;
  logic [31:0] cfg_rdata;

  always #2 clk = ~clk;

  cfg_window_decoder dut (
    .clk(clk), .rst_n(rst_n), .io_valid(io_valid), .io_write(io_write),
    .io_waddr(io_waddr), .io_be(io_be), .io_wdata(io_wdata),
    .io_ready(io_ready), .io_rdata(io_rdata), .io_fwd(io_fwd),
    .cfg_req(cfg_req), .cfg_write(cfg_write), .cfg_type1(cfg_type1),
    .cfg_bus(cfg_bus), .cfg_dev(cfg_dev), .cfg_fn(cfg_fn), .cfg_off(cfg_off),
    .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .cfg_done(cfg_done),
    .cfg_rdata(cfg_rdata), .cfg_nodev(cfg_nodev)
  );

  int checks = 0;
  int errors = 0;
  bit mon_on = 1'b0;
  logic [31:0] exp_sel = 32'h0;   // behavioural model of the selector

  logic [7:0] c_bus; logic [4:0] c_dev; logic [2:0] c_fn; logic [5:0] c_off;
  logic [3:0] c_be;  logic c_wr, c_t1; logic [31:0] c_wd;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Every clock: compare requests with the model selector.
  always @(negedge clk) begin
    if (mon_on) begin
      checks++;
      if (cfg_req && !exp_sel[31]) begin
        errors++;
        $display("FAIL R5 request while disabled actual=1 expected=0");
      end
      checks++;
      if (cfg_req && (cfg_type1 !== (cfg_bus != 8'h0))) begin
        errors++;
        $display("FAIL R6 type flag actual=%b expected=%b", cfg_type1, cfg_bus != 8'h0);
      end
      checks++;
      if (io_ready && io_fwd) begin
        errors++;
        $display("FAIL R3 ready with forward actual=1 expected=0");
      end
    end
  end

  task automatic io_op(input bit wr, input logic [13:0] wa, input logic [3:0] be,
                       input logic [31:0] wd, input int lat, input bit nodev,
                       input logic [31:0] devdata, output logic [31:0] rd,
                       output int nreq, output bit fwd, output bit rdy);
    bit got = 0, sent = 0;
    int cnt = 0;
    nreq = 0; rdy = 0; rd = 'x;
    @(negedge clk);
    io_valid = 1'b1; io_write = wr; io_waddr = wa; io_be = be; io_wdata = wd;
    #1;
    fwd = io_fwd;
    if (fwd) begin
      @(negedge clk);
      rdy = io_ready;
      io_valid = 1'b0;
      return;
    end
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      cfg_done = 1'b0;
      if (io_ready) begin
        rd = io_rdata; rdy = 1'b1; io_valid = 1'b0;
        break;
      end
      if (cfg_req && sent) nreq++;
      if (cfg_req && !got) begin
        got = 1; nreq++;
        c_bus = cfg_bus; c_dev = cfg_dev; c_fn = cfg_fn; c_off = cfg_off;
        c_be = cfg_be; c_wr = cfg_write; c_t1 = cfg_type1; c_wd = cfg_wdata;
      end
      if (got && !sent) begin
        if (cnt == lat) begin
          cfg_done = 1'b1; cfg_rdata = devdata; cfg_nodev = nodev; sent = 1;
        end
        cnt++;
      end
    end
    io_valid = 1'b0;
  endtask

  task automatic sel_write(input logic [31:0] d, input string tag);
    logic [31:0] rd; int n; bit f, r;
    io_op(1, AP, 4'hF, d, 0, 0, 0, rd, n, f, r);
    chk({tag, " selector write ready"}, {31'h0, r}, 32'h1);
    exp_sel = d & 32'h80FFFFFC;
  endtask

  task automatic sel_read(input string tag);
    logic [31:0] rd; int n; bit f, r;
    io_op(0, AP, 4'hF, 0, 0, 0, 0, rd, n, f, r);
    chk({tag, " selector readback"}, rd, exp_sel);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R7 watchdog expired actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    logic [31:0] rd; int n; bit f, r;
    rst_n = 1'b0; io_valid = 1'b0; io_write = 1'b0; io_waddr = '0; io_be = '0;
    io_wdata = '0; cfg_done = 1'b0; cfg_rdata = '0; cfg_nodev = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk("R1 cfg_req after reset", {31'h0, cfg_req}, 32'h0);
    chk("R1 io_ready after reset", {31'h0, io_ready}, 32'h0);
    mon_on = 1'b1;
    sel_read("R1");

    // R2 readback masking
    sel_write(32'h80000000, "R2"); sel_read("R2 enable only");
    sel_write(32'h00000000, "R2"); sel_read("R2 zero");
    sel_write(32'hFFFFFFFF, "R2"); sel_read("R2 all ones masked");
    chk("R2 mask value", exp_sel, 32'h80FFFFFC);

    // Selector: bus 0x12, dev 5, fn 3, offset 0x44 (dword 0x11)
    sel_write(32'h80122B44, "R4");
    // R3 narrow accesses to the selector port and a foreign port
    io_op(1, AP, 4'b1000, 32'h0, 0, 0, 0, rd, n, f, r);
    chk("R3 byte write forwarded", {31'h0, f}, 32'h1);
    chk("R3 byte write no ready", {31'h0, r}, 32'h0);
    io_op(1, AP, 4'b1100, 32'h0, 0, 0, 0, rd, n, f, r);
    chk("R3 word write forwarded", {31'h0, f}, 32'h1);
    sel_read("R3 unchanged after narrow writes");
    io_op(0, AP, 4'b0001, 32'h0, 0, 0, 0, rd, n, f, r);
    chk("R3 byte read forwarded", {31'h0, f}, 32'h1);
    io_op(0, OP, 4'hF, 32'h0, 0, 0, 0, rd, n, f, r);
    chk("R3 foreign port forwarded", {31'h0, f}, 32'h1);

    // R4 R6 R7 read with latency 2
    io_op(0, DP, 4'hF, 32'h0, 2, 0, 32'hDEADBEEF, rd, n, f, r);
    chk("R4 one request", n, 1);
    chk("R4 bus", {24'h0, c_bus}, 32'h12);
    chk("R4 dev", {27'h0, c_dev}, 32'h5);
    chk("R4 fn", {29'h0, c_fn}, 32'h3);
    chk("R4 offset", {26'h0, c_off}, 32'h11);
    chk("R4 be", {28'h0, c_be}, 32'hF);
    chk("R4 read dir", {31'h0, c_wr}, 32'h0);
    chk("R6 nonzero bus type1", {31'h0, c_t1}, 32'h1);
    chk("R7 read data", rd, 32'hDEADBEEF);

    // R4 R7 byte write with latency 4
    io_op(1, DP, 4'b0100, 32'h00AB0000, 4, 0, 32'h0, rd, n, f, r);
    chk("R4 write one request", n, 1);
    chk("R4 write be", {28'h0, c_be}, 32'h4);
    chk("R4 write dir", {31'h0, c_wr}, 32'h1);
    chk("R4 write data", c_wd, 32'h00AB0000);
    chk("R7 write ready", {31'h0, r}, 32'h1);

    // R8 no device
    io_op(0, DP, 4'hF, 32'h0, 1, 1, 32'h12345678, rd, n, f, r);
    chk("R8 no device read", rd, 32'hFFFFFFFF);

    // R9 R6 device 31 function 7 on bus 0, offset 0x3F
    sel_write(32'h8000FFFC, "R9");
    io_op(0, DP, 4'hF, 32'h0, 0, 0, 32'h0BADF00D, rd, n, f, r);
    chk("R9 dev 31", {27'h0, c_dev}, 32'h1F);
    chk("R9 fn 7", {29'h0, c_fn}, 32'h7);
    chk("R9 offset 0x3F", {26'h0, c_off}, 32'h3F);
    chk("R6 bus 0 type0", {31'h0, c_t1}, 32'h0);
    chk("R7 read data 2", rd, 32'h0BADF00D);

    // R5 enable clear
    sel_write(32'h00122B44, "R5");
    io_op(0, DP, 4'hF, 32'h0, 0, 0, 32'h11111111, rd, n, f, r);
    chk("R5 no request on read", n, 0);
    chk("R5 read all ones", rd, 32'hFFFFFFFF);
    io_op(1, DP, 4'hF, 32'h55AA55AA, 0, 0, 32'h0, rd, n, f, r);
    chk("R5 no request on write", n, 0);
    chk("R5 write completes", {31'h0, r}, 32'h1);
    sel_read("R5 selector kept");

    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule